// File: doc/BRIEF.md
# GPIO Expander Port Register Bank

This block holds the control state of a 24-pin general-purpose I/O expander, organised as three 8-bit ports. Each port has four registers: a captured input byte, an output drive byte, a polarity-inversion byte and a direction byte. A bus-side controller, outside this block, presents a 4-bit register index with write data and a write strobe. It also presents a second 4-bit index for reading and gets the selected byte back combinationally.

On the pin side the bank drives a per-pin output value and a per-pin output enable, which stand in for a tri-state pad. It receives the per-pin input levels. Input levels are latched only when the bus logic pulses a sample strobe, so a byte being shifted out stays stable. Polarity inversion changes only the value reported for input registers. It never changes what is driven onto a pin.

Top module: `gpio_reg_bank`

## Requirements
- R1: After reset, every output bit is 1, every inversion bit is 0 and every direction bit is 1. All pins therefore start as inputs: `pin_oe_o` is all 0 and `pin_o` is all 0.
- R2: A direction bit of 0 makes its pin an output: `pin_oe_o` is 1 and `pin_o` equals the stored output bit. A direction bit of 1 makes the pin an input: `pin_oe_o` is 0 and `pin_o` is 0, whatever the output bit holds.
- R3: Reading an output register returns the stored byte, never the level present on `pin_i`.
- R4: Reading an input register returns the captured pin level XOR the port's inversion byte. This holds for pins configured as outputs as well as for inputs.
- R5: The input capture registers load `pin_i` only on a cycle where `sample_i` is 1. On all other cycles they hold their value.
- R6: A write to an input register index (0, 1 or 2) changes no register and no pin output.
- R7: Indices 3, 7, 11 and 15 read as zero, and writes to them change nothing.
- R8: Index bits [3:2] select the register kind: 0 = input, 1 = output, 2 = inversion, 3 = direction. Index bits [1:0] select the port, 0 to 2, and port p owns pins 8p to 8p+7.
- R9: Driving `rst_ni` low restores every default of R1 at once, without waiting for a clock edge, and keeps them while it stays low. Captured inputs reset to 0.
- R10: A write with `wr_en_i` at 1 takes effect at the next rising clock edge. From then on it is visible on reads and on the pin outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | 4 | Register index for the write |
| wr_data_i | input | 8 | Write data |
| rd_idx_i | input | 4 | Register index for the read |
| rd_data_o | output | 8 | Read data for `rd_idx_i` |
| sample_i | input | 1 | Loads the input capture registers from `pin_i` |
| pin_i | input | 24 | Pin input levels |
| pin_o | output | 24 | Pin drive value, 0 where the driver is disabled |
| pin_oe_o | output | 24 | Pin driver enable |

## Verification
The hardest case to reach is a pin configured as an output whose external level disagrees with the driven value, while its inversion bit is set. The input read must then show the inverted external level, and the output read must still show the stored flop. The bench reaches this case by writing direction and output bytes first, then driving `pin_i` with patterns unrelated to `pin_o` and pulsing `sample_i`. A long random phase then mixes writes to all 16 indices, including the reserved and input-only ones, with independent sample pulses. A mid-run asynchronous reset follows the random phase.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned KIND_W = IDX_W - SEL_W;

  typedef enum logic [KIND_W-1:0] {
    KIND_IN  = 2'd0,
    KIND_OUT = 2'd1,
    KIND_POL = 2'd2,
    KIND_CFG = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/gpio_idx_decode.sv
module gpio_idx_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 3
) (
  input  logic [IDX_W-1:0] idx_i,
  output reg_kind_e        kind_o,
  output logic [SEL_W-1:0] port_o,
  output logic             hit_o
);
  localparam int unsigned MAX_PORTS = 1 << SEL_W;

  always_comb begin
    kind_o = reg_kind_e'(idx_i[IDX_W-1:SEL_W]);
    port_o = idx_i[SEL_W-1:0];
    hit_o  = (32'(port_o) < NUM_PORTS) && (NUM_PORTS <= MAX_PORTS);
  end
endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [PORT_W-1:0] pin_i,
  input  logic              we_out_i,
  input  logic              we_pol_i,
  input  logic              we_cfg_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  reg_kind_e         rd_kind_i,
  output logic [PORT_W-1:0] rd_data_o,
  output logic [PORT_W-1:0] pin_o,
  output logic [PORT_W-1:0] pin_oe_o
);
  logic [PORT_W-1:0] in_q, out_q, pol_q, cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= '1;
      pol_q <= '0;
      cfg_q <= '1;
    end else begin
      if (sample_i) in_q  <= pin_i;
      if (we_out_i) out_q <= wdata_i;
      if (we_pol_i) pol_q <= wdata_i;
      if (we_cfg_i) cfg_q <= wdata_i;
    end
  end

  // cfg bit 1 = input, driver off
  assign pin_oe_o = ~cfg_q;
  assign pin_o    = out_q & ~cfg_q;

  always_comb begin
    unique case (rd_kind_i)
      KIND_IN:  rd_data_o = in_q ^ pol_q;
      KIND_OUT: rd_data_o = out_q;
      KIND_POL: rd_data_o = pol_q;
      KIND_CFG: rd_data_o = cfg_q;
      default:  rd_data_o = '0;
    endcase
  end

  a_r5_hold_without_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(in_q));
  a_r10_out_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_out_i |=> out_q == $past(wdata_i));
  a_r2_oe_after_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_cfg_i |=> pin_oe_o == ~$past(wdata_i));
  a_r3_out_ignores_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_out_i && rd_kind_i == KIND_OUT) |=> (rd_kind_i != KIND_OUT || $stable(rd_data_o)));
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned PORT_W    = 8,
  localparam int unsigned PIN_W    = NUM_PORTS * PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [PORT_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [PORT_W-1:0] rd_data_o,
  input  logic              sample_i,
  input  logic [PIN_W-1:0]  pin_i,
  output logic [PIN_W-1:0]  pin_o,
  output logic [PIN_W-1:0]  pin_oe_o
);
  reg_kind_e        wr_kind, rd_kind;
  logic [SEL_W-1:0] wr_port, rd_port;
  logic             wr_hit, rd_hit;
  logic [PORT_W-1:0] port_rd [NUM_PORTS];

  gpio_idx_decode #(.NUM_PORTS(NUM_PORTS)) u_wr_dec (
    .idx_i(wr_idx_i), .kind_o(wr_kind), .port_o(wr_port), .hit_o(wr_hit));
  gpio_idx_decode #(.NUM_PORTS(NUM_PORTS)) u_rd_dec (
    .idx_i(rd_idx_i), .kind_o(rd_kind), .port_o(rd_port), .hit_o(rd_hit));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic sel;
    assign sel = wr_en_i && wr_hit && (wr_port == SEL_W'(p));

    gpio_port_slice #(.PORT_W(PORT_W)) u_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sample_i (sample_i),
      .pin_i    (pin_i[p*PORT_W +: PORT_W]),
      .we_out_i (sel && wr_kind == KIND_OUT),
      .we_pol_i (sel && wr_kind == KIND_POL),
      .we_cfg_i (sel && wr_kind == KIND_CFG),
      .wdata_i  (wr_data_i),
      .rd_kind_i(rd_kind),
      .rd_data_o(port_rd[p]),
      .pin_o    (pin_o[p*PORT_W +: PORT_W]),
      .pin_oe_o (pin_oe_o[p*PORT_W +: PORT_W])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (rd_hit && rd_port == SEL_W'(p)) rd_data_o = port_rd[p];
  end

  a_r7_reserved_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(rd_idx_i[SEL_W-1:0]) >= NUM_PORTS) |-> rd_data_o == '0);
  a_r7_reserved_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && 32'(wr_idx_i[SEL_W-1:0]) >= NUM_PORTS) |=> ($stable(pin_o) && $stable(pin_oe_o)));
  a_r6_input_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i[IDX_W-1:SEL_W] == 2'd0) |=> ($stable(pin_o) && $stable(pin_oe_o)));
  a_r2_no_drive_when_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o & ~pin_oe_o) == '0);
endmodule

// File: tb/sim_gpio_reg_bank.sv
`timescale 1ns/1ps
module sim_gpio_reg_bank;
  localparam int NP = 3;
  localparam int W  = 8;
  localparam int PW = NP * W;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_idx = '0;
  logic [W-1:0]  wr_data = '0;
  logic [3:0]    rd_idx = '0;
  logic [W-1:0]  rd_data;
  logic          sample = 1'b0;
  logic [PW-1:0] pin_in = '0;
  logic [PW-1:0] pin_out, pin_oe;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  gpio_reg_bank u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .sample_i(sample), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe));

  // reference model
  logic [PW-1:0] m_in, m_out, m_pol, m_cfg;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_in = '0; m_out = '1; m_pol = '0; m_cfg = '1;
    end else begin
      if (sample) m_in = pin_in;
      if (wr_en && wr_idx[1:0] != 2'd3) begin
        case (wr_idx[3:2])
          2'd1: m_out[wr_idx[1:0]*W +: W] = wr_data;
          2'd2: m_pol[wr_idx[1:0]*W +: W] = wr_data;
          2'd3: m_cfg[wr_idx[1:0]*W +: W] = wr_data;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [W-1:0] exp_rd(input logic [3:0] idx);
    int p = int'(idx[1:0]);
    if (p >= NP) return '0;
    case (idx[3:2])
      2'd0:    return m_in[p*W +: W] ^ m_pol[p*W +: W];
      2'd1:    return m_out[p*W +: W];
      2'd2:    return m_pol[p*W +: W];
      default: return m_cfg[p*W +: W];
    endcase
  endfunction

  task automatic compare(input string tag);
    logic [W-1:0]  er = exp_rd(rd_idx);
    logic [PW-1:0] eo = m_out & ~m_cfg;
    logic [PW-1:0] ee = ~m_cfg;
    vectors += 3;
    if (rd_data !== er) begin
      errors++;
      $display("FAIL %s rd idx %0d: got %h exp %h", tag, rd_idx, rd_data, er);
    end
    if (pin_out !== eo) begin
      errors++;
      $display("FAIL %s pin_o: got %h exp %h", tag, pin_out, eo);
    end
    if (pin_oe !== ee) begin
      errors++;
      $display("FAIL %s pin_oe_o: got %h exp %h", tag, pin_oe, ee);
    end
  endtask

  // compare at negedge, then present the next inputs
  task automatic step(input string tag, input logic we, input logic [3:0] wi,
                      input logic [W-1:0] wd, input logic [3:0] ri, input logic smp);
    @(negedge clk);
    compare(tag);
    wr_en = we; wr_idx = wi; wr_data = wd; rd_idx = ri; sample = smp;
  endtask

  task automatic wr(input string tag, input logic [3:0] wi, input logic [W-1:0] wd);
    step(tag, 1'b1, wi, wd, wi, 1'b0);
  endtask

  task automatic rd(input string tag, input logic [3:0] ri);
    step(tag, 1'b0, 4'd0, '0, ri, 1'b0);
  endtask

  initial begin
    // R1: defaults while and after reset
    for (int i = 0; i < 3; i++) rd("R1", 4'(12 + i));
    @(negedge clk); rst_ni = 1'b1;
    for (int i = 0; i < 16; i++) rd((i % 4 == 3) ? "R7" : "R1", 4'(i));
    rd("R1", 4'd0);

    // R8/R10: direction and output bytes per port
    wr("R10", 4'd12, 8'h0F); wr("R10", 4'd13, 8'h00); wr("R10", 4'd14, 8'hA5);
    wr("R8", 4'd4, 8'h3C);  wr("R8", 4'd5, 8'h96);   wr("R8", 4'd6, 8'h5A);
    for (int i = 4; i < 15; i++) rd("R8", 4'(i));
    rd("R2", 4'd6);

    // R5: pin change without sample is not captured
    pin_in = 24'hC3_7E_19;
    rd("R5", 4'd0); rd("R5", 4'd1); rd("R5", 4'd2);
    step("R5", 1'b0, 4'd0, '0, 4'd0, 1'b1);
    rd("R5", 4'd0); rd("R5", 4'd1); rd("R5", 4'd2);

    // R4: inversion on inputs, including output-configured pins
    wr("R4", 4'd8, 8'hFF); wr("R4", 4'd9, 8'h0F); wr("R4", 4'd10, 8'hA0);
    rd("R4", 4'd0); rd("R4", 4'd1); rd("R4", 4'd2);
    rd("R2", 4'd5);

    // R3: output readback ignores disagreeing pin levels
    pin_in = ~pin_out;
    step("R3", 1'b0, 4'd0, '0, 4'd5, 1'b1);
    rd("R3", 4'd4); rd("R3", 4'd5); rd("R3", 4'd6); rd("R4", 4'd1);

    // R6: writes to input indices are inert
    wr("R6", 4'd0, 8'h00); wr("R6", 4'd1, 8'hFF); wr("R6", 4'd2, 8'h55);
    rd("R6", 4'd1); rd("R6", 4'd5); rd("R6", 4'd13);

    // R7: reserved indices
    wr("R7", 4'd3, 8'hFF); wr("R7", 4'd7, 8'h00); wr("R7", 4'd11, 8'hFF); wr("R7", 4'd15, 8'h00);
    rd("R7", 4'd7); rd("R7", 4'd15); rd("R7", 4'd14); rd("R7", 4'd6);

    // random mix
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 3) == 0) pin_in = PW'($urandom);
      step("R10", 1'($urandom), 4'($urandom), 8'($urandom), 4'($urandom), 1'($urandom));
    end

    // R9: asynchronous reset mid-run
    wr("R9", 4'd13, 8'h00);
    @(negedge clk); compare("R9");
    wr_en = 1'b0;
    #2 rst_ni = 1'b0;
    #1 compare("R9");
    rd("R9", 4'd13); rd("R9", 4'd5); rd("R9", 4'd1);
    @(negedge clk); rst_ni = 1'b1;
    rd("R9", 4'd8); rd("R9", 4'd12);
    @(negedge clk); compare("R9");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule